// File: doc/BRIEF.md
# Frame-Aware Receive Byte Queue

This block stores received frames byte by byte and keeps a short queue of per-frame records beside the byte store. A receiver writes bytes with an end-of-frame marker and a 4-bit error code. The host sees a 16-bit status word for the frame at the head of the queue, reads that frame's bytes through a single read port, and then drops the rest of the frame with a discard pulse. A read does not remove a frame record. Only a discard does that.

The byte store can fill up, and so can the record queue, and each has its own stall flag. When the byte store is full, arriving bytes are dropped and that frame is marked as overrun. When the record queue is full, a new frame is refused as a whole. A read past the end of the head frame leaves a sticky failure flag set, and only a receive reset clears it.

Top module: `rx_frame_fifo`

## Requirements
- R1: While no complete frame is queued, `head_status` is `{1'b1, 4'b0000, n}` with n (bits 10:0) equal to the bytes stored so far for the frame being received (0 when none).
- R2: While a complete frame is queued, `head_status` is `{1'b0, code, rem}`. Bits 14:11 carry the head frame's 4-bit code exactly as given. Bit 14 set means error: 1000 overrun, 1011 runt, 1100 alignment, 1101 CRC, 1001 oversize. 0010 means dribble bits, and any other code means no error. Bits 10:0 carry the unread bytes remaining in the head frame.
- R3: `rd_data` always shows the next unread byte of the head frame. A `rd_en` pulse on a frame with bytes left moves to the next byte and lowers the remaining count by one, both visible after the clock edge.
- R4: When SQ_DEPTH (8) complete frames are queued, a frame that starts is refused entirely and `stat_ovr_flag` is set. The flag clears on the next discard that removes a frame.
- R5: When the byte store holds DEPTH (64) bytes, `ovr_flag` is high and further bytes are dropped. The frame being received then gets code 1000 and a count of only the stored bytes. The flag clears once the fill drops to DEPTH-OVR_HYST (60).
- R6: A `rd_en` with no complete frame queued, or with no bytes left in the head frame, consumes nothing and sets `underrun_flag` and `adapter_fail`. These flags stay set until `rx_reset` or `rst_n`.
- R7: `receiving` goes high the cycle after the first accepted byte of a multi-byte frame and falls the cycle after its last byte. It stays low for refused frames.
- R8: `discard` frees all unread bytes of the head frame and moves to the next record. With no complete frame queued it has no effect. When it coincides with `rd_en`, the discard wins and the read is ignored.
- R9: `rx_complete` is high exactly while at least one complete frame is queued.
- R10: After `rst_n`, `head_status` is 16'h8000 and all flags and `rx_complete` are low.
- R11: A synchronous `rx_reset` empties the block and clears every flag, including the underrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_reset | input | 1 | Synchronous receive reset, empties everything |
| wr_valid | input | 1 | A received byte is present |
| wr_data | input | 8 | Received byte |
| wr_last | input | 1 | This byte ends the frame |
| wr_code | input | 4 | Frame error code, sampled with wr_last |
| rd_en | input | 1 | Consume one byte of the head frame |
| discard | input | 1 | Drop the rest of the head frame and its record |
| rd_data | output | 8 | Next unread byte of the head frame |
| head_status | output | 16 | Status word of the head frame |
| rx_complete | output | 1 | At least one complete frame is queued |
| receiving | output | 1 | A frame is being written |
| ovr_flag | output | 1 | Byte store full, with release hysteresis |
| stat_ovr_flag | output | 1 | Record queue full, a frame was refused |
| underrun_flag | output | 1 | Read past the end of received data |
| adapter_fail | output | 1 | Failure indication raised by underrun |

## Verification
On every cycle, the assertions check these relationships:
- The incomplete bit of the status word agrees with `rx_complete`.
- The underrun flag is sticky across everything except `rx_reset`.
- The overrun and underrun flags only rise on a write or a read.
- The record-full flag only falls after a discard.
- A receive reset leaves everything cleared.

The actual status values, byte ordering, the refusal of a ninth frame, the 60-byte release point of the overrun flag and the discard priority over a read depend on exact contents, so only the bench's scenarios can show them.

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
  parameter int ADDR_W   = 6,
  parameter int SQ_DEPTH = 8,
  parameter int OVR_HYST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_reset,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic        wr_last,
  input  logic [3:0]  wr_code,
  input  logic        rd_en,
  input  logic        discard,
  output logic [7:0]  rd_data,
  output logic [15:0] head_status,
  output logic        rx_complete,
  output logic        receiving,
  output logic        ovr_flag,
  output logic        stat_ovr_flag,
  output logic        underrun_flag,
  output logic        adapter_fail
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam int SQ_W  = $clog2(SQ_DEPTH);
  localparam int LEN_W = 11;
  localparam logic [3:0]       CODE_OVERRUN = 4'b1000;
  localparam logic [CNT_W-1:0] FULL_CNT     = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] RELEASE_CNT  = CNT_W'(DEPTH - OVR_HYST);
  localparam logic [SQ_W:0]    SQ_FULL      = (SQ_W+1)'(SQ_DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] byte_cnt, byte_cnt_nxt, free_n;
  logic [LEN_W-1:0] sq_len  [SQ_DEPTH];
  logic [3:0]       sq_code [SQ_DEPTH];
  logic [SQ_W-1:0]  sq_wp, sq_rp;
  logic [SQ_W:0]    sq_cnt;
  logic [LEN_W-1:0] rd_off, cur_len, head_len, head_rem;
  logic [3:0]       head_code;
  logic in_frame, drop_frame, frame_ovr;
  logic have_frame, start, reject, frame_on, full;
  logic wr_take, wr_lost, push, do_discard, rd_ok, rd_bad;

  assign head_len   = sq_len[sq_rp];
  assign head_code  = sq_code[sq_rp];
  assign head_rem   = head_len - rd_off;
  assign have_frame = (sq_cnt != '0);
  assign start      = wr_valid && !in_frame;
  assign reject     = start && (sq_cnt == SQ_FULL);
  assign frame_on   = in_frame ? !drop_frame : !reject;
  assign full       = (byte_cnt == FULL_CNT);
  assign wr_take    = wr_valid && frame_on && !full;
  assign wr_lost    = wr_valid && frame_on && full;
  assign push       = wr_valid && frame_on && wr_last;
  assign do_discard = discard && have_frame;
  assign rd_ok      = rd_en && !discard && have_frame && (rd_off != head_len);
  assign rd_bad     = rd_en && !discard && !rd_ok;
  assign free_n     = do_discard ? CNT_W'(head_rem) : CNT_W'(rd_ok);
  assign byte_cnt_nxt = byte_cnt + CNT_W'(wr_take) - free_n;

  assign rd_data      = mem[rd_ptr];
  assign head_status  = have_frame ? {1'b0, head_code, head_rem}
                                   : {1'b1, 4'b0000, cur_len};
  assign rx_complete  = have_frame;
  assign receiving    = in_frame && !drop_frame;
  assign adapter_fail = underrun_flag;

  always_ff @(posedge clk) begin
    if (wr_take) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SQ_DEPTH; i++) begin
        sq_len[i]  <= '0;
        sq_code[i] <= '0;
      end
    end else if (push) begin
      sq_len[sq_wp]  <= cur_len + LEN_W'(wr_take);
      sq_code[sq_wp] <= (frame_ovr || wr_lost) ? CODE_OVERRUN : wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; byte_cnt <= '0;
      sq_wp <= '0; sq_rp <= '0; sq_cnt <= '0;
      rd_off <= '0; cur_len <= '0;
      in_frame <= 1'b0; drop_frame <= 1'b0; frame_ovr <= 1'b0;
      ovr_flag <= 1'b0; stat_ovr_flag <= 1'b0; underrun_flag <= 1'b0;
    end else if (rx_reset) begin
      wr_ptr <= '0; rd_ptr <= '0; byte_cnt <= '0;
      sq_wp <= '0; sq_rp <= '0; sq_cnt <= '0;
      rd_off <= '0; cur_len <= '0;
      in_frame <= 1'b0; drop_frame <= 1'b0; frame_ovr <= 1'b0;
      ovr_flag <= 1'b0; stat_ovr_flag <= 1'b0; underrun_flag <= 1'b0;
    end else begin
      if (wr_take) wr_ptr <= wr_ptr + ADDR_W'(1);

      if (do_discard)  rd_ptr <= rd_ptr + head_rem[ADDR_W-1:0];
      else if (rd_ok)  rd_ptr <= rd_ptr + ADDR_W'(1);

      if (do_discard)  rd_off <= '0;
      else if (rd_ok)  rd_off <= rd_off + LEN_W'(1);

      byte_cnt <= byte_cnt_nxt;

      if (wr_valid) in_frame <= !wr_last;
      if (start)    drop_frame <= reject;

      if (push)         cur_len <= '0;
      else if (wr_take) cur_len <= cur_len + LEN_W'(1);

      if (push)         frame_ovr <= 1'b0;
      else if (wr_lost) frame_ovr <= 1'b1;

      if (push)       sq_wp <= sq_wp + SQ_W'(1);
      if (do_discard) sq_rp <= sq_rp + SQ_W'(1);
      sq_cnt <= sq_cnt + (SQ_W+1)'(push) - (SQ_W+1)'(do_discard);

      if (reject)          stat_ovr_flag <= 1'b1;
      else if (do_discard) stat_ovr_flag <= 1'b0;

      if (byte_cnt_nxt == FULL_CNT)         ovr_flag <= 1'b1;
      else if (byte_cnt_nxt <= RELEASE_CNT) ovr_flag <= 1'b0;

      if (rd_bad) underrun_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_frame_fifo_chk.sv
module rx_frame_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_reset,
  input logic wr_valid,
  input logic rd_en,
  input logic discard,
  input logic head_flag,
  input logic rx_complete,
  input logic ovr_flag,
  input logic stat_ovr_flag,
  input logic underrun_flag,
  input logic adapter_fail
);
  // R1
  incomplete_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_complete |-> head_flag);
  // R2
  complete_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_complete |-> !head_flag);
  // R4
  stat_ovr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_ovr_flag) |-> ($past(discard) || $past(rx_reset)));
  // R5
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(wr_valid));
  // R6
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_flag && !rx_reset) |=> underrun_flag);
  // R6
  underrun_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adapter_fail) |-> $past(rd_en));
  // R11
  rx_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (!underrun_flag && !rx_complete && !ovr_flag && !stat_ovr_flag));
endmodule

bind rx_frame_fifo rx_frame_fifo_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .wr_valid(wr_valid),
  .rd_en(rd_en), .discard(discard), .head_flag(head_status[15]),
  .rx_complete(rx_complete), .ovr_flag(ovr_flag), .stat_ovr_flag(stat_ovr_flag),
  .underrun_flag(underrun_flag), .adapter_fail(adapter_fail)
);

// File: tb/rx_frame_fifo_tb.sv
module rx_frame_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {len[7:0], code[3:0], expected head_status[15:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {8'd3,  4'h0, 16'h0003},
    {8'd5,  4'hD, 16'h6805},
    {8'd7,  4'h2, 16'h1007},
    {8'd1,  4'hB, 16'h5801},
    {8'd20, 4'h9, 16'h4814},
    {8'd4,  4'h7, 16'h3804}
  };

  logic clk = 1'b0;
  logic rst_n, rx_reset, wr_valid, wr_last, rd_en, discard;
  logic [7:0] wr_data;
  logic [3:0] wr_code;
  logic [7:0] rd_data;
  logic [15:0] head_status;
  logic rx_complete, receiving, ovr_flag, stat_ovr_flag, underrun_flag, adapter_fail;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_last(wr_last), .wr_code(wr_code), .rd_en(rd_en),
    .discard(discard), .rd_data(rd_data), .head_status(head_status),
    .rx_complete(rx_complete), .receiving(receiving), .ovr_flag(ovr_flag),
    .stat_ovr_flag(stat_ovr_flag), .underrun_flag(underrun_flag),
    .adapter_fail(adapter_fail)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input int len, input logic [3:0] code, input logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      wr_valid = 1'b1; wr_data = base + 8'(i); wr_last = (i == len-1); wr_code = code;
      @(negedge clk);
    end
    wr_valid = 1'b0; wr_last = 1'b0; wr_code = 4'h0;
  endtask

  task automatic rd1();
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic drop1();
    discard = 1'b1; @(negedge clk); discard = 1'b0;
  endtask

  task automatic rxr();
    rx_reset = 1'b1; @(negedge clk); rx_reset = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_reset = 1'b0; wr_valid = 1'b0; wr_last = 1'b0;
    wr_data = 8'h00; wr_code = 4'h0; rd_en = 1'b0; discard = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 status", 32'(head_status), 32'h8000);
    chk("R10 flags", {ovr_flag, stat_ovr_flag, underrun_flag, adapter_fail, rx_complete, receiving}, 0);

    // R2 R3 R8 R9 table of frames
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0]  len  = VEC[v][27:20];
      logic [3:0]  code = VEC[v][19:16];
      logic [15:0] exp  = VEC[v][15:0];
      logic [7:0]  base = 8'(v * 16);
      send(int'(len), code, base);
      chk("R9 complete", 32'(rx_complete), 1);
      chk("R2 status", 32'(head_status), 32'(exp));
      chk("R3 first byte", 32'(rd_data), 32'(base));
      rd1();
      chk("R3 remaining", 32'(head_status), 32'(exp - 16'd1));
      if (len > 1) chk("R3 second byte", 32'(rd_data), 32'(base + 8'd1));
      drop1();
      chk("R8 discard empties", {31'd0, rx_complete}, 0);
      chk("R1 empty status", 32'(head_status), 32'h8000);
    end

    // R7 R1 receiving and partial status
    wr_valid = 1'b1; wr_data = 8'hA0; wr_last = 1'b0; @(negedge clk);
    chk("R7 receiving high", 32'(receiving), 1);
    chk("R1 partial count", 32'(head_status), 32'h8001);
    wr_data = 8'hA1; @(negedge clk);
    chk("R1 partial count 2", 32'(head_status), 32'h8002);
    wr_data = 8'hA2; wr_last = 1'b1; @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
    chk("R7 receiving low", 32'(receiving), 0);
    chk("R9 complete", 32'(rx_complete), 1);
    chk("R2 no-error status", 32'(head_status), 32'h0003);
    drop1();
    send(1, 4'h0, 8'h55);
    chk("R7 single byte", 32'(receiving), 0);
    drop1();

    // R3 R8 discard partway and discard/read priority
    send(5, 4'h0, 8'h10);
    send(3, 4'hC, 8'h40);
    rd1(); rd1();
    chk("R3 byte after two reads", 32'(rd_data), 32'h12);
    chk("R3 remaining 3", 32'(head_status), 32'h0003);
    drop1();
    chk("R8 next head status", 32'(head_status), 32'h6003);
    chk("R8 next head byte", 32'(rd_data), 32'h40);
    rd_en = 1'b1; discard = 1'b1; @(negedge clk); rd_en = 1'b0; discard = 1'b0;
    chk("R8 discard wins", 32'(head_status), 32'h8000);
    chk("R8 no underrun", 32'(underrun_flag), 0);
    drop1();
    chk("R8 empty discard ignored", {head_status, 7'd0, rx_complete, 7'd0, underrun_flag}, 32'h80000000);

    // R4 record queue limit
    for (int f = 0; f < 8; f++) send(2, 4'h0, 8'(f));
    chk("R4 no flag at eight", 32'(stat_ovr_flag), 0);
    wr_valid = 1'b1; wr_data = 8'hEE; wr_last = 1'b0; @(negedge clk);
    chk("R4 refused not receiving", 32'(receiving), 0);
    chk("R4 flag set", 32'(stat_ovr_flag), 1);
    wr_last = 1'b1; @(negedge clk); wr_valid = 1'b0; wr_last = 1'b0;
    drop1();
    chk("R4 flag cleared by discard", 32'(stat_ovr_flag), 0);
    for (int f = 0; f < 7; f++) drop1();
    chk("R4 ninth frame was dropped", 32'(rx_complete), 0);

    // R5 byte store full
    send(70, 4'h0, 8'h00);
    chk("R5 overrun flag", 32'(ovr_flag), 1);
    chk("R5 overrun code and count", 32'(head_status), 32'h4040);
    rd1(); rd1(); rd1();
    chk("R5 flag held at 61", 32'(ovr_flag), 1);
    rd1();
    chk("R5 flag released at 60", 32'(ovr_flag), 0);
    chk("R5 stored byte order", 32'(rd_data), 32'h04);
    drop1();
    chk("R5 emptied", 32'(head_status), 32'h8000);

    // R6 R11 underrun
    send(2, 4'h0, 8'h70);
    rd1(); rd1();
    chk("R6 no underrun at end", 32'(underrun_flag), 0);
    rd1();
    chk("R6 underrun set", {30'd0, underrun_flag, adapter_fail}, 3);
    drop1();
    chk("R6 underrun sticky", 32'(underrun_flag), 1);
    rd1();
    chk("R6 still sticky", 32'(adapter_fail), 1);
    send(3, 4'h0, 8'h80);
    rxr();
    chk("R11 cleared", {29'd0, underrun_flag, rx_complete, adapter_fail}, 0);
    chk("R11 status empty", 32'(head_status), 32'h8000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule